// File: doc/BRIEF.md
# Vector Register-Group Shrink Stall Controller

This block sits in the dispatch stage of a vector unit. It keeps the active vector type: the element-width code and a 3-bit register-grouping code. It inspects every configuration update offered to it. When the new grouping is smaller than the one already in force, instructions issued under the old grouping may still be writing registers that a narrower instruction is about to read. For example, a two-register group starting at v6 also writes v7, and a following half-register instruction may read v7. In that case the controller moves into a drain state. It blocks the instruction handshake until the backend signals that nothing is in flight.

The grouping code is read as a signed base-2 logarithm of the group size. The codes 101, 110 and 111 stand for 1/8, 1/4 and 1/2. The codes 000 to 011 stand for 1, 2, 4 and 8, and 100 is reserved. Because of this signed reading, moves from integer to fractional groups are detected, and so are moves between fractional groups. A comparison of raw code values would miss some of these moves.

Top module: `vlmul_stall_ctrl`

## Requirements
- R1: After reset, cur_lmul is 000, cur_sew is 0, stall and illegal_cfg are low, and insn_ready is high.
- R2: A legal update accepted while not stalled whose grouping code, read as a signed 3-bit value, is less than the current one sets stall high from the next cycle.
- R3: A move from an integer group (bit 2 clear) to a fractional group (bit 2 set) always stalls. A 2-register to 1/2-register move is one example.
- R4: A legal update whose signed grouping value is equal to or greater than the current one leaves stall low.
- R5: Every accepted legal update, shrinking or not, loads cur_sew and cur_lmul at the next clock edge.
- R6: An update carrying code 100 leaves cur_sew and cur_lmul unchanged and raises no stall. It drives illegal_cfg high for exactly the following cycle.
- R7: While stall is high, insn_ready and insn_issue are low.
- R8: While stalled, stall stays high as long as be_idle is low. Stall drops in the cycle after be_idle is sampled high.
- R9: Configuration updates offered while stall is high are ignored, with the vtype left unchanged.
- R10: While not stalled, insn_ready is high and insn_issue equals insn_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration update strobe |
| cfg_sew | input | SEW_W | New element-width code |
| cfg_lmul | input | 3 | New grouping code |
| insn_valid | input | 1 | Front end offers an instruction |
| insn_ready | output | 1 | Dispatch accepts an instruction |
| insn_issue | output | 1 | Instruction handed over this cycle |
| be_idle | input | 1 | Backend has no operation in flight |
| stall | output | 1 | Drain state active |
| illegal_cfg | output | 1 | One-cycle flag for a reserved grouping code |
| cur_sew | output | SEW_W | Active element-width code |
| cur_lmul | output | 3 | Active grouping code |

## Verification
The bench sweeps every ordered pair of the seven legal grouping codes. It checks the stall decision against a signed-order reference. A design that stalled only on a falling code between integer groups would let 2 to 1/2, 1/2 to 1/8 and similar moves pass without draining, and it would fail those pairs. The reserved code is checked to leave the vtype untouched, so a design that loaded it would corrupt later comparisons. Updates offered during a long drain are checked to be ignored. The exit is checked to fall exactly one cycle after idle is seen, so a design that left early or stayed one cycle too long shows as a stall mismatch.

// File: rtl/vstall_pkg.sv
package vstall_pkg;
  localparam int LMUL_W = 3;
  typedef logic [LMUL_W-1:0] lmul_t;
  localparam lmul_t LMUL_RSVD = 3'b100;
  localparam lmul_t LMUL_ONE  = 3'b000;

  typedef enum logic {ST_RUN = 1'b0, ST_DRAIN = 1'b1} dstate_e;

  function automatic logic lmul_is_frac(lmul_t c);
    return c[LMUL_W-1];
  endfunction
endpackage

// File: rtl/lmul_cmp.sv
module lmul_cmp
  import vstall_pkg::*;
(
  input  lmul_t old_lmul,
  input  lmul_t new_lmul,
  output logic  is_rsvd,
  output logic  shrink
);
  logic signed [LMUL_W-1:0] old_log2;
  logic signed [LMUL_W-1:0] new_log2;

  always_comb begin
    old_log2 = $signed(old_lmul);
    new_log2 = $signed(new_lmul);
    is_rsvd  = (new_lmul == LMUL_RSVD);
    shrink   = (new_log2 < old_log2);
  end
endmodule

// File: rtl/vtype_reg.sv
module vtype_reg
  import vstall_pkg::*;
#(
  parameter int SEW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [SEW_W-1:0] sew_d,
  input  lmul_t            lmul_d,
  output logic [SEW_W-1:0] sew_q,
  output lmul_t            lmul_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sew_q  <= '0;
      lmul_q <= LMUL_ONE;
    end else if (load_en) begin
      sew_q  <= sew_d;
      lmul_q <= lmul_d;
    end
  end

  // R6: the reserved code never reaches the register
  assert_no_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lmul_q != LMUL_RSVD);

  // R9: without a load the vtype holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(lmul_q) && $stable(sew_q)));
endmodule

// File: rtl/dispatch_fsm.sv
module dispatch_fsm
  import vstall_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_valid,
  input  logic cfg_rsvd,
  input  logic cfg_shrink,
  input  logic be_idle,
  output logic stall,
  output logic load_en,
  output logic illegal_q
);
  dstate_e state_q, state_d;
  logic    illegal_d;
  logic    take_cfg;

  always_comb begin
    take_cfg  = (state_q == ST_RUN) && cfg_valid;
    load_en   = take_cfg && !cfg_rsvd;
    illegal_d = take_cfg && cfg_rsvd;
    state_d   = state_q;
    case (state_q)
      ST_RUN:   if (load_en && cfg_shrink) state_d = ST_DRAIN;
      ST_DRAIN: if (be_idle)               state_d = ST_RUN;
      default:                             state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= illegal_d;
    end
  end

  assign stall = (state_q == ST_DRAIN);

  // R2: an accepted shrinking update enters the drain state
  assert_shrink_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && cfg_valid && !cfg_rsvd && cfg_shrink) |=> stall);

  // R4: an accepted non-shrinking update keeps dispatch running
  assert_grow_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && cfg_valid && !cfg_shrink) |=> !stall);

  // R8: drain holds until idle and ends right after it
  assert_drain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !be_idle) |=> stall);
  assert_drain_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && be_idle) |=> !stall);

  // R6: reserved code flags for one cycle only
  assert_illegal_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |=> !illegal_q || $past(cfg_valid && cfg_rsvd && !stall));
endmodule

// File: rtl/vlmul_stall_ctrl.sv
module vlmul_stall_ctrl
  import vstall_pkg::*;
#(
  parameter int SEW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [SEW_W-1:0] cfg_sew,
  input  logic [2:0]       cfg_lmul,
  input  logic             insn_valid,
  output logic             insn_ready,
  output logic             insn_issue,
  input  logic             be_idle,
  output logic             stall,
  output logic             illegal_cfg,
  output logic [SEW_W-1:0] cur_sew,
  output logic [2:0]       cur_lmul
);
  lmul_t lmul_q;
  logic  rsvd, shrink, load_en;

  lmul_cmp u_cmp (
    .old_lmul (lmul_q),
    .new_lmul (cfg_lmul),
    .is_rsvd  (rsvd),
    .shrink   (shrink)
  );

  dispatch_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_rsvd   (rsvd),
    .cfg_shrink (shrink),
    .be_idle    (be_idle),
    .stall      (stall),
    .load_en    (load_en),
    .illegal_q  (illegal_cfg)
  );

  vtype_reg #(.SEW_W(SEW_W)) u_vtype (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .sew_d   (cfg_sew),
    .lmul_d  (cfg_lmul),
    .sew_q   (cur_sew),
    .lmul_q  (lmul_q)
  );

  assign cur_lmul   = lmul_q;
  assign insn_ready = !stall;
  assign insn_issue = insn_valid && insn_ready;

  // R7: nothing is handed over during a drain
  assert_no_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !insn_issue);

  // R3: integer to fractional move always drains
  assert_int2frac_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && cfg_valid && !lmul_is_frac(cur_lmul) && lmul_is_frac(cfg_lmul)
     && cfg_lmul != LMUL_RSVD) |=> stall);

  // R5: accepted legal update lands in the vtype
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && cfg_valid && cfg_lmul != LMUL_RSVD) |=>
      (cur_lmul == $past(cfg_lmul) && cur_sew == $past(cfg_sew)));

  // R6: reserved code keeps vtype and raises the flag
  assert_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && cfg_valid && cfg_lmul == LMUL_RSVD) |=>
      (illegal_cfg && $stable(cur_lmul) && !stall));
endmodule

// File: tb/sim_vlmul_stall_ctrl.sv
module sim_vlmul_stall_ctrl;
  localparam int SEW_W = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 1'b0, insn_valid = 1'b0, be_idle = 1'b0;
  logic [SEW_W-1:0] cfg_sew = '0;
  logic [2:0] cfg_lmul = '0;
  logic insn_ready, insn_issue, stall, illegal_cfg;
  logic [SEW_W-1:0] cur_sew;
  logic [2:0] cur_lmul;

  int n_chk = 0, n_fail = 0;
  logic [2:0] m_lmul;
  logic [SEW_W-1:0] m_sew;
  logic m_stall, m_ill;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlmul_stall_ctrl #(.SEW_W(SEW_W)) u0 (.*);

  function automatic logic ref_shrink(logic [2:0] o, logic [2:0] n);
    return $signed(n) < $signed(o);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // called at a negedge: drive, check handshake, advance model, check state
  task automatic step(logic cv, logic [SEW_W-1:0] sw, logic [2:0] lm, logic iv, logic idl);
    cfg_valid = cv; cfg_sew = sw; cfg_lmul = lm; insn_valid = iv; be_idle = idl;
    #1;
    chk(m_stall ? "R7" : "R10", "insn_ready", insn_ready, !m_stall);
    chk(m_stall ? "R7" : "R10", "insn_issue", insn_issue, iv && !m_stall);
    m_ill = 1'b0;
    if (!m_stall) begin
      m_tag = "R4";
      if (cv) begin
        if (lm == 3'b100) begin
          m_ill = 1'b1; m_tag = "R6";
        end else begin
          if (ref_shrink(m_lmul, lm)) begin
            m_stall = 1'b1;
            m_tag = (!m_lmul[2] && lm[2]) ? "R3" : "R2";
          end else m_tag = "R4";
          m_lmul = lm; m_sew = sw;
        end
      end
    end else begin
      m_tag = cv ? "R9" : "R8";
      if (idl) m_stall = 1'b0;
    end
    @(posedge clk); @(negedge clk);
    chk(m_tag, "stall", stall, m_stall);
    chk(m_tag, "illegal_cfg", illegal_cfg, m_ill);
    chk(cv ? (m_tag == "R2" || m_tag == "R3" || m_tag == "R4" ? "R5" : m_tag) : m_tag,
        "cur_lmul", cur_lmul, m_lmul);
    chk(m_tag, "cur_sew", cur_sew, m_sew);
  endtask

  task automatic drain();
    while (m_stall) step(1'b0, '0, 3'b000, 1'b0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_lmul = 3'b000; m_sew = '0; m_stall = 1'b0; m_ill = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cur_lmul", cur_lmul, 0);
    chk("R1", "cur_sew", cur_sew, 0);
    chk("R1", "stall", stall, 0);
    chk("R1", "illegal_cfg", illegal_cfg, 0);
    chk("R1", "insn_ready", insn_ready, 1);

    // R2/R3/R4 sweep of all legal pairs
    for (int o = 0; o < 8; o++) begin
      for (int n = 0; n < 8; n++) begin
        if (o == 4 || n == 4) continue;
        step(1'b1, 3'(o), 3'(o), 1'b0, 1'b1); drain();
        step(1'b1, 3'(n), 3'(n), 1'b1, 1'b0); drain();
      end
    end

    // R3 hazard case: 2-register group then half-register group, slow drain
    step(1'b1, 3'd1, 3'b001, 1'b0, 1'b1); drain();
    step(1'b1, 3'd1, 3'b111, 1'b1, 1'b0);
    // R9 updates during drain ignored, R8 held while busy
    for (int i = 0; i < 6; i++) step(1'b1, 3'd5, 3'b011, 1'b1, 1'b0);
    step(1'b0, '0, 3'b000, 1'b1, 1'b1);
    step(1'b0, '0, 3'b000, 1'b1, 1'b0);

    // R6 reserved code
    step(1'b1, 3'd6, 3'b100, 1'b0, 1'b0);
    step(1'b0, '0, 3'b000, 1'b1, 1'b0);
    step(1'b1, 3'd2, 3'b100, 1'b1, 1'b1);
    step(1'b1, 3'd2, 3'b100, 1'b1, 1'b1);

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 3) == 0, 3'($urandom), 3'($urandom), 1'($urandom),
           ($urandom % 4) == 0);
    end
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule